// File: doc/BRIEF.md
# Permission-Aware Set-Associative Tag Directory

This block is the tag-and-state half of a set-associative cache controller. It stores no line data. For each way of each set it keeps a valid flag, the stored line address, a permission state and a reservation lock owner. A controller sends it one command per cycle with a line-aligned address. It gets back a registered result: a success flag, the selected way, whether the set has room, and, for a victim probe, the address of the line to evict.

A tag match does not make a hit on its own. The permission state of the line decides whether a load, instruction fetch or store may proceed. A line in the NotPresent state is treated as absent by every lookup. Replacement uses true LRU, kept as per-way age ranks within each set. Commands that break their preconditions are refused with an error flag and leave every stored field unchanged.

The number of sets is CACHE_BYTES / WAYS / LINE_BYTES. It must be a power of two greater than 1, and WAYS must be a power of two.

Top module: `tag_dir`

## Requirements
- R1: The set index is `addr_i[IDX_LO +: log2(SETS)]`. Addresses that differ in that field never compete for the same ways, and the full address is kept as the tag.
- R2: Permission codes on `perm_i` are 0 NotPresent, 1 Invalid, 2 ReadOnly, 3 ReadWrite and 4 Busy. Command 11 (set-permission) writes `perm_i` into the lowest way whose valid entry holds the address, whatever that way's current permission. It returns `hit_o`=1 and that way. If no valid entry holds the address, the command is an error.
- R3: Commands 0 (load), 1 (fetch) and 2 (store) return `hit_o`=1 only when the address is present and its permission is ReadWrite, or its permission is ReadOnly and the command is not a store. `way_o` is the matching way, or 0 when nothing matches.
- R4: An entry holding the address with permission NotPresent counts as absent for access checks, for command 3 (presence test, `hit_o`=present), and for deallocation and the lock commands.
- R5: Any present match on commands 0 to 2 makes that way most-recently-used, even when the permission check fails. Command 5 (allocate) does this only when `touch_i` is 1. No other command changes recency. After reset, way 0 is most recent and the highest-numbered way is least recent.
- R6: The set is available when some valid entry holds the address, or when some way is empty or NotPresent. Command 4 returns `hit_o`=availability and `way_o`=lowest empty-or-NotPresent way (0 if none). `avail_o` reports availability for every command.
- R7: Command 5 is legal only when the address is absent and the set is available. It fills the lowest empty-or-NotPresent way, sets the permission to Invalid, clears the lock, and returns `hit_o`=1 and that way.
- R8: Command 6 (deallocate) on a present address empties its way and returns `hit_o`=1 and that way.
- R9: Command 7 (victim probe) is legal only when the set is not available. It returns `hit_o`=1, `way_o`=least-recently-used way and `victim_addr_o`=that way's stored address.
- R10: Command 8 sets the lock owner to `ctx_i`, command 9 clears it, and command 10 returns `hit_o`=1 only if a lock is held and its owner equals `ctx_i`. All three require the address to be present.
- R11: An illegal command (a precondition fails, or codes 12 to 15) returns `err_o`=1, `hit_o`=0, `way_o`=0 and `victim_addr_o`=0, and changes no stored state. `victim_addr_o` is 0 for every command other than a successful probe.
- R12: `req_ready_o` is always 1. A command accepted at a clock edge gives `rsp_valid_o`=1 with its results after the next edge only. After reset, all ways are empty and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Command valid |
| req_ready_o | output | 1 | Command ready, always 1 |
| cmd_i | input | 4 | Command code |
| addr_i | input | ADDR_W | Line address |
| ctx_i | input | CTX_W | Lock context for lock set and test |
| perm_i | input | 3 | Permission for set-permission |
| touch_i | input | 1 | Update recency on allocate |
| rsp_valid_o | output | 1 | Result valid |
| err_o | output | 1 | Command refused |
| hit_o | output | 1 | Command result flag |
| way_o | output | log2(WAYS) | Selected way |
| avail_o | output | 1 | Set availability for the address |
| victim_addr_o | output | ADDR_W | Address of the probed victim |

## Verification
The bench keeps its own model of every way and its recency ranks, and runs long command mixes over a few tags per set, so sets fill, overflow and drain many times. It targets the following cases:
- A store to a ReadOnly line. A design that ignored permissions would grant the store.
- A permission-refused access that must still refresh recency. A design that missed this would report the wrong victim on the next probe.
- A NotPresent entry that must look absent but still be refillable.
- An allocate that must drop a stale lock owner.
- Refused commands that must leave the state intact. A leak would surface as wrong presence or victim answers in later commands.

// File: rtl/tag_dir_pkg.sv
package tag_dir_pkg;
  localparam int PERM_W = 3;
  localparam logic [PERM_W-1:0] PERM_NP   = 3'd0;
  localparam logic [PERM_W-1:0] PERM_INV  = 3'd1;
  localparam logic [PERM_W-1:0] PERM_RO   = 3'd2;
  localparam logic [PERM_W-1:0] PERM_RW   = 3'd3;
  localparam logic [PERM_W-1:0] PERM_BUSY = 3'd4;

  localparam int CMD_W = 4;
  localparam logic [CMD_W-1:0] CMD_LOAD     = 4'd0;
  localparam logic [CMD_W-1:0] CMD_FETCH    = 4'd1;
  localparam logic [CMD_W-1:0] CMD_STORE    = 4'd2;
  localparam logic [CMD_W-1:0] CMD_PRESENT  = 4'd3;
  localparam logic [CMD_W-1:0] CMD_AVAIL    = 4'd4;
  localparam logic [CMD_W-1:0] CMD_ALLOC    = 4'd5;
  localparam logic [CMD_W-1:0] CMD_DEALLOC  = 4'd6;
  localparam logic [CMD_W-1:0] CMD_PROBE    = 4'd7;
  localparam logic [CMD_W-1:0] CMD_LOCK_SET = 4'd8;
  localparam logic [CMD_W-1:0] CMD_LOCK_CLR = 4'd9;
  localparam logic [CMD_W-1:0] CMD_LOCK_TST = 4'd10;
  localparam logic [CMD_W-1:0] CMD_SET_PERM = 4'd11;
endpackage

// File: rtl/tag_dir_lowest.sv
module tag_dir_lowest #(
  parameter int N     = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vec_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  assign any_o = |vec_i;

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tag_dir_match.sv
module tag_dir_match
  import tag_dir_pkg::*;
#(
  parameter int WAYS   = 4,
  parameter int ADDR_W = 16,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             vld_i,
  input  logic [WAYS-1:0][ADDR_W-1:0] tag_i,
  input  logic [WAYS-1:0][PERM_W-1:0] perm_i,
  input  logic [ADDR_W-1:0]           addr_i,
  output logic                        hit_any_o,
  output logic [WAY_W-1:0]            hit_way_o,
  output logic                        raw_any_o,
  output logic [WAY_W-1:0]            raw_way_o,
  output logic                        free_any_o,
  output logic [WAY_W-1:0]            free_way_o
);
  logic [WAYS-1:0] raw_vec, hit_vec, free_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign raw_vec[w]  = vld_i[w] && (tag_i[w] == addr_i);
    assign hit_vec[w]  = raw_vec[w] && (perm_i[w] != PERM_NP);
    assign free_vec[w] = !vld_i[w] || (perm_i[w] == PERM_NP);
  end

  tag_dir_lowest #(.N(WAYS)) i_hit  (.vec_i(hit_vec),  .any_o(hit_any_o),  .idx_o(hit_way_o));
  tag_dir_lowest #(.N(WAYS)) i_raw  (.vec_i(raw_vec),  .any_o(raw_any_o),  .idx_o(raw_way_o));
  tag_dir_lowest #(.N(WAYS)) i_free (.vec_i(free_vec), .any_o(free_any_o), .idx_o(free_way_o));
endmodule

// File: rtl/tag_dir_lru.sv
module tag_dir_lru #(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [SET_W-1:0] set_i,
  input  logic [WAY_W-1:0] way_i,
  output logic [WAY_W-1:0] victim_o
);
  // rank 0 = most recent, WAYS-1 = least recent; ranks stay a permutation
  logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] age_q;
  logic [WAYS-1:0] oldest;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == way_i)
          age_q[set_i][w] <= '0;
        else if (age_q[set_i][w] < age_q[set_i][way_i])
          age_q[set_i][w] <= age_q[set_i][w] + 1'b1;
      end
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_old
    assign oldest[w] = (age_q[set_i][w] == WAY_W'(WAYS - 1));
  end

  tag_dir_lowest #(.N(WAYS)) i_vic (.vec_i(oldest), .any_o(), .idx_o(victim_o));

  // R9
  victim_unique_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(oldest) == 1);
endmodule

// File: rtl/tag_dir.sv
module tag_dir
  import tag_dir_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int CACHE_BYTES = 256,
  parameter int LINE_BYTES  = 16,
  parameter int WAYS        = 4,
  parameter int IDX_LO      = 4,
  parameter int CTX_W       = 4,
  localparam int SETS  = CACHE_BYTES / WAYS / LINE_BYTES,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CTX_W-1:0]  ctx_i,
  input  logic [PERM_W-1:0] perm_i,
  input  logic              touch_i,
  output logic              rsp_valid_o,
  output logic              err_o,
  output logic              hit_o,
  output logic [WAY_W-1:0]  way_o,
  output logic              avail_o,
  output logic [ADDR_W-1:0] victim_addr_o
);
  logic [SETS-1:0][WAYS-1:0]             vld_q, lkv_q;
  logic [SETS-1:0][WAYS-1:0][ADDR_W-1:0] tag_q;
  logic [SETS-1:0][WAYS-1:0][PERM_W-1:0] perm_q;
  logic [SETS-1:0][WAYS-1:0][CTX_W-1:0]  lkc_q;

  logic [SET_W-1:0] set_idx;
  logic             hit_any, raw_any, free_any, avail;
  logic [WAY_W-1:0] hit_way, raw_way, free_way, victim_way;
  logic [PERM_W-1:0] sel_perm;
  logic             ok, res, lru_touch;
  logic [WAY_W-1:0] sel_way;
  logic [ADDR_W-1:0] sel_vic;
  logic             acc;

  assign req_ready_o = 1'b1;
  assign acc     = req_valid_i;
  assign set_idx = addr_i[IDX_LO +: SET_W];

  tag_dir_match #(.WAYS(WAYS), .ADDR_W(ADDR_W)) i_match (
    .vld_i(vld_q[set_idx]), .tag_i(tag_q[set_idx]), .perm_i(perm_q[set_idx]),
    .addr_i(addr_i),
    .hit_any_o(hit_any), .hit_way_o(hit_way),
    .raw_any_o(raw_any), .raw_way_o(raw_way),
    .free_any_o(free_any), .free_way_o(free_way)
  );

  tag_dir_lru #(.SETS(SETS), .WAYS(WAYS)) i_lru (
    .clk_i(clk_i), .rst_ni(rst_ni), .touch_i(lru_touch),
    .set_i(set_idx), .way_i(sel_way), .victim_o(victim_way)
  );

  assign avail    = raw_any || free_any;
  assign sel_perm = perm_q[set_idx][hit_way];

  always_comb begin
    ok        = 1'b1;
    res       = 1'b1;
    sel_way   = '0;
    sel_vic   = '0;
    lru_touch = 1'b0;
    unique case (cmd_i)
      CMD_LOAD, CMD_FETCH, CMD_STORE: begin
        sel_way   = hit_any ? hit_way : '0;
        lru_touch = acc && hit_any;
        res = hit_any && ((sel_perm == PERM_RW) ||
                          ((sel_perm == PERM_RO) && (cmd_i != CMD_STORE)));
      end
      CMD_PRESENT: begin
        res     = hit_any;
        sel_way = hit_any ? hit_way : '0;
      end
      CMD_AVAIL: begin
        res     = avail;
        sel_way = free_any ? free_way : '0;
      end
      CMD_ALLOC: begin
        ok        = !hit_any && free_any;
        sel_way   = free_way;
        lru_touch = acc && ok && touch_i;
      end
      CMD_DEALLOC, CMD_LOCK_SET, CMD_LOCK_CLR: begin
        ok      = hit_any;
        sel_way = hit_way;
      end
      CMD_LOCK_TST: begin
        ok      = hit_any;
        sel_way = hit_way;
        res     = lkv_q[set_idx][hit_way] && (lkc_q[set_idx][hit_way] == ctx_i);
      end
      CMD_PROBE: begin
        ok      = !avail;
        sel_way = victim_way;
        sel_vic = tag_q[set_idx][victim_way];
      end
      CMD_SET_PERM: begin
        ok      = raw_any;
        sel_way = raw_way;
      end
      default: ok = 1'b0;
    endcase
  end

  // directory state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      lkv_q  <= '0;
      tag_q  <= '0;
      perm_q <= '0;
      lkc_q  <= '0;
    end else if (acc && ok) begin
      unique case (cmd_i)
        CMD_ALLOC: begin
          vld_q[set_idx][sel_way]  <= 1'b1;
          tag_q[set_idx][sel_way]  <= addr_i;
          perm_q[set_idx][sel_way] <= PERM_INV;
          lkv_q[set_idx][sel_way]  <= 1'b0;
          lkc_q[set_idx][sel_way]  <= '0;
        end
        CMD_DEALLOC:  vld_q[set_idx][sel_way]  <= 1'b0;
        CMD_SET_PERM: perm_q[set_idx][sel_way] <= perm_i;
        CMD_LOCK_SET: begin
          lkv_q[set_idx][sel_way] <= 1'b1;
          lkc_q[set_idx][sel_way] <= ctx_i;
        end
        CMD_LOCK_CLR: lkv_q[set_idx][sel_way] <= 1'b0;
        default: ;
      endcase
    end
  end

  // registered response
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o   <= 1'b0;
      err_o         <= 1'b0;
      hit_o         <= 1'b0;
      way_o         <= '0;
      avail_o       <= 1'b0;
      victim_addr_o <= '0;
    end else begin
      rsp_valid_o <= acc;
      if (acc) begin
        err_o         <= !ok;
        hit_o         <= ok && res;
        way_o         <= ok ? sel_way : '0;
        avail_o       <= avail;
        victim_addr_o <= ok ? sel_vic : '0;
      end
    end
  end

  // R12
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  // R12
  rsp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  // R11
  err_no_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !hit_o);
  // R11
  err_keeps_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && err_o) |-> (vld_q == $past(vld_q) && perm_q == $past(perm_q)
                                && lkv_q == $past(lkv_q)));
  // R3
  store_needs_rw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && hit_o && $past(cmd_i) == CMD_STORE) |-> ($past(sel_perm) == PERM_RW));
  // R7
  alloc_clears_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !err_o && $past(cmd_i) == CMD_ALLOC) |-> !lkv_q[$past(set_idx)][way_o]);
endmodule

// File: tb/test_tag_dir.sv
module test_tag_dir;
  localparam int CLK_NS = 20;
  localparam int SETS = 4, WAYS = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0, touch_i = 1'b0;
  logic [3:0] cmd_i = '0, ctx_i = '0;
  logic [15:0] addr_i = '0;
  logic [2:0] perm_i = '0;
  logic req_ready_o, rsp_valid_o, err_o, hit_o, avail_o;
  logic [1:0] way_o;
  logic [15:0] victim_addr_o;

  int checks = 0, fails = 0;

  // bench model of the directory
  logic        m_vld [SETS][WAYS];
  logic [15:0] m_tag [SETS][WAYS];
  logic [2:0]  m_perm[SETS][WAYS];
  logic        m_lkv [SETS][WAYS];
  logic [3:0]  m_lkc [SETS][WAYS];
  int          m_age [SETS][WAYS];

  always #(CLK_NS/2) clk = ~clk;

  tag_dir i_tag_dir (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .cmd_i(cmd_i), .addr_i(addr_i), .ctx_i(ctx_i), .perm_i(perm_i), .touch_i(touch_i),
    .rsp_valid_o(rsp_valid_o), .err_o(err_o), .hit_o(hit_o), .way_o(way_o),
    .avail_o(avail_o), .victim_addr_o(victim_addr_o)
  );

  task automatic model_touch(input int s, input int w);
    int a = m_age[s][w];
    for (int v = 0; v < WAYS; v++) begin
      if (v == w) m_age[s][v] = 0;
      else if (m_age[s][v] < a) m_age[s][v] = m_age[s][v] + 1;
    end
  endtask

  function automatic string rq_of(input int c);
    case (c)
      0, 1, 2: return "R3";
      3: return "R4";
      4: return "R6";
      5: return "R7";
      6: return "R8";
      7: return "R9";
      8, 9, 10: return "R10";
      11: return "R2";
      default: return "R11";
    endcase
  endfunction

  task automatic run(input string rq, input int c, input int t, input int s,
                     input int cx, input int pm, input bit tc);
    logic [15:0] a = 16'((t << 6) | (s << 4));
    int hw = -1, rw = -1, fw = -1, vw = 0;
    bit e_err = 0, e_hit = 0, e_av;
    int e_way = 0;
    logic [15:0] e_vic = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (m_vld[s][w] && m_tag[s][w] == a) begin
        if (rw < 0) rw = w;
        if (m_perm[s][w] != 0 && hw < 0) hw = w;
      end
      if ((!m_vld[s][w] || m_perm[s][w] == 0) && fw < 0) fw = w;
      if (m_age[s][w] == WAYS - 1) vw = w;
    end
    e_av = (rw >= 0) || (fw >= 0);
    case (c)
      0, 1, 2: if (hw >= 0) begin
        e_way = hw;
        e_hit = (m_perm[s][hw] == 3) || (m_perm[s][hw] == 2 && c != 2);
        model_touch(s, hw);
      end
      3: begin e_hit = hw >= 0; e_way = (hw >= 0) ? hw : 0; end
      4: begin e_hit = e_av; e_way = (fw >= 0) ? fw : 0; end
      5: if (hw < 0 && fw >= 0) begin
        e_hit = 1; e_way = fw;
        m_vld[s][fw] = 1; m_tag[s][fw] = a; m_perm[s][fw] = 3'd1;
        m_lkv[s][fw] = 0; m_lkc[s][fw] = 0;
        if (tc) model_touch(s, fw);
      end else e_err = 1;
      6: if (hw >= 0) begin e_hit = 1; e_way = hw; m_vld[s][hw] = 0; end else e_err = 1;
      7: if (!e_av) begin e_hit = 1; e_way = vw; e_vic = m_tag[s][vw]; end else e_err = 1;
      8: if (hw >= 0) begin e_hit = 1; e_way = hw; m_lkv[s][hw] = 1; m_lkc[s][hw] = 4'(cx); end
         else e_err = 1;
      9: if (hw >= 0) begin e_hit = 1; e_way = hw; m_lkv[s][hw] = 0; end else e_err = 1;
      10: if (hw >= 0) begin e_way = hw; e_hit = m_lkv[s][hw] && m_lkc[s][hw] == 4'(cx); end
          else e_err = 1;
      11: if (rw >= 0) begin e_hit = 1; e_way = rw; m_perm[s][rw] = 3'(pm); end else e_err = 1;
      default: e_err = 1;
    endcase
    @(negedge clk);
    cmd_i = 4'(c); addr_i = a; ctx_i = 4'(cx); perm_i = 3'(pm); touch_i = tc;
    req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    checks++;
    if (rsp_valid_o !== 1'b1 || err_o !== e_err || hit_o !== e_hit || way_o !== 2'(e_way) ||
        avail_o !== e_av || victim_addr_o !== e_vic) begin
      fails++;
      $display("FAIL %s cmd %0d addr %h: v/err/hit/way/av/vic got %b %b %b %0d %b %h exp 1 %b %b %0d %b %h",
               rq, c, a, rsp_valid_o, err_o, hit_o, way_o, avail_o, victim_addr_o,
               e_err, e_hit, e_way, e_av, e_vic);
    end
  endtask

  task automatic check_idle(input string rq);
    @(negedge clk);
    checks++;
    if (rsp_valid_o !== 1'b0 || req_ready_o !== 1'b1) begin
      fails++;
      $display("FAIL %s idle: rsp_valid %b ready %b exp 0 1", rq, rsp_valid_o, req_ready_o);
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_vld[s][w] = 0; m_tag[s][w] = 0; m_perm[s][w] = 0;
        m_lkv[s][w] = 0; m_lkc[s][w] = 0; m_age[s][w] = w;
      end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R12 reset state
    checks++;
    if (rsp_valid_o !== 0 || err_o !== 0 || hit_o !== 0 || way_o !== 0 ||
        avail_o !== 0 || victim_addr_o !== 0 || req_ready_o !== 1) begin
      fails++;
      $display("FAIL R12 reset outputs v%b e%b h%b w%0d a%b vic%h exp all 0", rsp_valid_o,
               err_o, hit_o, way_o, avail_o, victim_addr_o);
    end
    // R1 same upper bits, different set fields are independent
    run("R1", 5, 1, 0, 0, 0, 1);
    run("R1", 5, 1, 1, 0, 0, 1);
    run("R1", 3, 1, 2, 0, 0, 0);
    check_idle("R12");
    // R2 / R3 permission gating
    run("R2", 11, 1, 0, 0, 2, 0);
    run("R3", 0, 1, 0, 0, 0, 0);
    run("R3", 1, 1, 0, 0, 0, 0);
    run("R3", 2, 1, 0, 0, 0, 0);
    run("R2", 11, 1, 0, 0, 3, 0);
    run("R3", 2, 1, 0, 0, 0, 0);
    run("R2", 11, 1, 0, 0, 4, 0);
    run("R3", 0, 1, 0, 0, 0, 0);
    // R4 NotPresent looks absent but is refillable
    run("R2", 11, 1, 0, 0, 0, 0);
    run("R4", 3, 1, 0, 0, 0, 0);
    run("R4", 8, 1, 0, 3, 0, 0);
    run("R4", 5, 1, 0, 0, 0, 0);
    // R5 recency: fill set 3 without touch, then a refused store touches
    for (int t = 0; t < 4; t++) run("R7", 5, t, 3, 0, 0, 0);
    run("R9", 7, 0, 3, 0, 0, 0);
    run("R5", 2, 3, 3, 0, 0, 0);
    run("R5", 7, 0, 3, 0, 0, 0);
    run("R11", 5, 4, 3, 0, 0, 1);
    run("R8", 6, 2, 3, 0, 0, 0);
    run("R8", 3, 2, 3, 0, 0, 0);
    run("R6", 4, 4, 3, 0, 0, 0);
    run("R5", 5, 4, 3, 0, 0, 1);
    run("R5", 7, 0, 3, 0, 0, 0);
    // R10 locks; R7 allocate drops the owner
    run("R10", 8, 0, 3, 5, 0, 0);
    run("R10", 10, 0, 3, 5, 0, 0);
    run("R10", 10, 0, 3, 4, 0, 0);
    run("R10", 9, 0, 3, 0, 0, 0);
    run("R10", 10, 0, 3, 5, 0, 0);
    run("R10", 8, 0, 3, 0, 0, 0);
    run("R8", 6, 0, 3, 0, 0, 0);
    run("R7", 5, 0, 3, 0, 0, 0);
    run("R7", 10, 0, 3, 0, 0, 0);
    // R11 illegal codes and probe on available set
    run("R11", 15, 0, 1, 0, 0, 0);
    run("R11", 12, 1, 1, 0, 0, 0);
    run("R11", 7, 1, 1, 0, 0, 0);
    run("R11", 6, 5, 1, 0, 0, 0);
    check_idle("R12");
    // mixed sweep
    for (int i = 0; i < 6000; i++) begin
      int c = ($urandom % 4 == 0) ? 5 : int'($urandom % 16);
      run(rq_of(c), c, int'($urandom % 6), int'($urandom % 4), int'($urandom % 4),
          int'($urandom % 5), 1'($urandom));
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule